// File: doc/BRIEF.md
# Bridge Interrupt Status Controller

This block collects event pulses from a bus bridge into two status registers and turns them into a single level-sensitive interrupt line. Four bus error conditions land in a 16-bit error-flag register. Software clears these flags by writing ones, so a value read from the register and written straight back clears exactly the flags that were seen. Eight local events land in an 8-bit event register. Software clears that register by writing zeros, so a write of zero discards every pending event.

An 8-bit mask with the same bit layout as the event register selects which events may interrupt. A global enable bit in a control halfword gates the whole interrupt path. Software reaches all of this through a halfword register port with per-byte write enables. Reads are combinational on the selected halfword. The detection logic for each event sits elsewhere, and each event arrives as a one-cycle pulse.

Top module: `brg_irq_ctrl`

## Requirements
- R1: After reset, every status bit, the mask and the global enable read zero, and `irq_out` is low.
- R2: A pulse on `bus_err_pulse[i]` sets a sticky flag in halfword 0: index 3 sets bit 15 (parity), index 2 sets bit 14 (system error), index 1 sets bit 13 (master abort) and index 0 sets bit 12 (target abort). Bits 11..0 of halfword 0 read zero.
- R3: A write to halfword 0 with byte lane 1 enabled clears each flag whose data bit is one and leaves each flag whose data bit is zero. Writing back a value just read clears every flag in it.
- R4: A pulse on `lb_evt_pulse[j]` sets bit j of the event register, which reads in bits 7..0 of halfword 1. The layout is 7 mailbox, 6 read abort, 5 write abort, 4 interrupt pin, 3 parity, 2 inbound queue post, 1 DMA channel 1 and 0 DMA channel 0. A set bit holds until software clears it.
- R5: A write to halfword 1 with byte lane 0 enabled clears each event bit whose data bit is zero and keeps each one whose data bit is one. Writing zero therefore clears all pending events.
- R6: The event mask is read and written in bits 15..8 of halfword 1, through byte lane 1.
- R7: The global interrupt enable is bit 10 of halfword 2, written through byte lane 1. All other bits of halfword 2 read zero.
- R8: `irq_out` is high exactly one clock after a cycle in which the enable is set and some event bit is set with its mask bit also set. It is low one clock after any cycle where that condition fails.
- R9: An event or error pulse that arrives in the same cycle as a clearing write leaves its bit set.
- R10: A write whose byte enable for a field's lane is zero leaves that field unchanged.
- R11: Halfword 3 is unmapped. It reads zero, and writes to it change no register.
- R12: The error flags alone never raise `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_hidx | input | 2 | Halfword index of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 2 | Byte-lane write enables |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected halfword |
| bus_err_pulse | input | 4 | One-cycle bus error event pulses |
| lb_evt_pulse | input | 8 | One-cycle local event pulses |
| irq_out | output | 1 | Registered interrupt level |

## Verification
The bench builds the block with its default widths: four error flags, eight events and a 16-bit halfword. That configuration is small enough to sweep every one of the 256 mask values against each of the eight single-event sources. It also covers every mask value with the enable cleared, so the expected interrupt level for each pair is a single bit test computed in the bench. The narrow configuration also lets the bench drive a pulse into every flag, run each clear rule on one lane and then the other, and land set-versus-clear collisions on both registers.

// File: rtl/brg_irq_pkg.sv
package brg_irq_pkg;
  localparam int unsigned HW_W = 16;

  typedef enum logic [0:0] {
    CLR_ONES_CLEAR  = 1'b0,
    CLR_ZEROS_CLEAR = 1'b1
  } clr_mode_e;

  typedef enum logic [1:0] {
    SEL_ERR  = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/brg_irq_rstsync.sv
module brg_irq_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/brg_irq_stsbank.sv
module brg_irq_stsbank
  import brg_irq_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter clr_mode_e   MODE = CLR_ONES_CLEAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_pulse,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] sts
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] sts_d;
  logic         sts_ce;

  generate
    if (MODE == CLR_ONES_CLEAR) begin : g_ones
      always_comb begin
        clr_vec = wr_en ? wr_data : '0;
      end
      // R3: flags written with one and not re-set are gone next cycle
      p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_pulse == '0) |=> ((sts & $past(wr_data)) == '0));
    end else begin : g_zeros
      always_comb begin
        clr_vec = wr_en ? ~wr_data : '0;
      end
      // R5: bits written with zero and not re-set are gone next cycle
      p_zero_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_pulse == '0) |=> ((sts & ~$past(wr_data)) == '0));
    end
  endgenerate

  always_comb begin
    sts_d  = (sts & ~clr_vec) | set_pulse;
    sts_ce = wr_en | (|set_pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
    end else if (sts_ce) begin
      sts <= sts_d;
    end
  end

  // R9: a pulse always leaves its bit set, clear write or not
  p_set_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> ((sts & $past(set_pulse)) == $past(set_pulse)));

  // R4: without pulse or write the status holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && set_pulse == '0) |=> $stable(sts));
endmodule

// File: rtl/brg_irq_regif.sv
module brg_irq_regif
  import brg_irq_pkg::*;
#(
  parameter int unsigned HIDX_W   = 2,
  parameter int unsigned EVT_W    = 8,
  parameter int unsigned ERR_W    = 4,
  parameter int unsigned ERR_LSB  = 12,
  parameter int unsigned EN_BIT   = 10,
  parameter int unsigned ERR_HIDX = 0,
  parameter int unsigned EVT_HIDX = 1,
  parameter int unsigned CTL_HIDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIDX_W-1:0] hidx,
  input  logic              wr,
  input  logic [1:0]        be,
  input  logic [HW_W-1:0]   wdata,
  output logic [HW_W-1:0]   rdata,
  input  logic [ERR_W-1:0]  err_sts,
  input  logic [EVT_W-1:0]  evt_sts,
  output logic              err_we,
  output logic [ERR_W-1:0]  err_wdata,
  output logic              evt_we,
  output logic [EVT_W-1:0]  evt_wdata,
  output logic [EVT_W-1:0]  msk,
  output logic              glb_en
);
  localparam int unsigned ERR_LANE = ERR_LSB / 8;
  localparam int unsigned EN_LANE  = EN_BIT / 8;
  localparam int unsigned MSK_LSB  = 8;

  reg_sel_e         sel;
  logic             msk_we;
  logic             en_we;
  logic [EVT_W-1:0] msk_d;
  logic             en_d;

  always_comb begin
    if (hidx == HIDX_W'(ERR_HIDX))      sel = SEL_ERR;
    else if (hidx == HIDX_W'(EVT_HIDX)) sel = SEL_EVT;
    else if (hidx == HIDX_W'(CTL_HIDX)) sel = SEL_CTL;
    else                                sel = SEL_NONE;
  end

  always_comb begin
    err_we    = wr && (sel == SEL_ERR) && be[ERR_LANE];
    err_wdata = wdata[ERR_LSB +: ERR_W];
    evt_we    = wr && (sel == SEL_EVT) && be[0];
    evt_wdata = wdata[EVT_W-1:0];
    msk_we    = wr && (sel == SEL_EVT) && be[1];
    en_we     = wr && (sel == SEL_CTL) && be[EN_LANE];
    msk_d     = msk_we ? wdata[MSK_LSB +: EVT_W] : msk;
    en_d      = en_we ? wdata[EN_BIT] : glb_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk    <= '0;
      glb_en <= 1'b0;
    end else begin
      if (msk_we) msk <= msk_d;
      if (en_we)  glb_en <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_ERR: rdata[ERR_LSB +: ERR_W] = err_sts;
      SEL_EVT: begin
        rdata[EVT_W-1:0]         = evt_sts;
        rdata[MSK_LSB +: EVT_W]  = msk;
      end
      SEL_CTL: rdata[EN_BIT] = glb_en;
      default: rdata = '0;
    endcase
  end

  // R10: mask lane disabled keeps the mask
  p_msk_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hidx == HIDX_W'(EVT_HIDX) && !be[1]) |=> $stable(msk));

  // R11: writes to the unmapped halfword touch neither mask nor enable
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hidx != HIDX_W'(EVT_HIDX) && hidx != HIDX_W'(CTL_HIDX))
      |=> ($stable(msk) && $stable(glb_en)));
endmodule

// File: rtl/brg_irq_comb.sv
module brg_irq_comb #(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] sts,
  input  logic [EVT_W-1:0] msk,
  input  logic             glb_en,
  output logic             irq
);
  logic irq_d;

  always_comb begin
    irq_d = glb_en & (|(sts & msk));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

  // R8: enable low forces the line low on the next cycle
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq);

  // R8: no masked-in source means no interrupt next cycle
  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & msk) == '0) |=> !irq);
endmodule

// File: rtl/brg_irq_ctrl.sv
module brg_irq_ctrl
  import brg_irq_pkg::*;
#(
  parameter int unsigned HIDX_W  = 2,
  parameter int unsigned EVT_W   = 8,
  parameter int unsigned ERR_W   = 4,
  parameter int unsigned ERR_LSB = 12,
  parameter int unsigned EN_BIT  = 10,
  parameter int unsigned RST_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIDX_W-1:0] reg_hidx,
  input  logic              reg_wr,
  input  logic [1:0]        reg_be,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [ERR_W-1:0]  bus_err_pulse,
  input  logic [EVT_W-1:0]  lb_evt_pulse,
  output logic              irq_out
);
  logic             rst_n_s;
  logic [ERR_W-1:0] err_sts;
  logic [EVT_W-1:0] evt_sts;
  logic             err_we;
  logic [ERR_W-1:0] err_wdata;
  logic             evt_we;
  logic [EVT_W-1:0] evt_wdata;
  logic [EVT_W-1:0] msk;
  logic             glb_en;

  brg_irq_rstsync #(.STAGES(RST_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  brg_irq_regif #(
    .HIDX_W(HIDX_W), .EVT_W(EVT_W), .ERR_W(ERR_W),
    .ERR_LSB(ERR_LSB), .EN_BIT(EN_BIT)
  ) u_regif (
    .clk(clk), .rst_n(rst_n_s),
    .hidx(reg_hidx), .wr(reg_wr), .be(reg_be), .wdata(reg_wdata),
    .rdata(reg_rdata),
    .err_sts(err_sts), .evt_sts(evt_sts),
    .err_we(err_we), .err_wdata(err_wdata),
    .evt_we(evt_we), .evt_wdata(evt_wdata),
    .msk(msk), .glb_en(glb_en)
  );

  brg_irq_stsbank #(.W(ERR_W), .MODE(CLR_ONES_CLEAR)) u_err (
    .clk(clk), .rst_n(rst_n_s), .set_pulse(bus_err_pulse),
    .wr_en(err_we), .wr_data(err_wdata), .sts(err_sts)
  );

  brg_irq_stsbank #(.W(EVT_W), .MODE(CLR_ZEROS_CLEAR)) u_evt (
    .clk(clk), .rst_n(rst_n_s), .set_pulse(lb_evt_pulse),
    .wr_en(evt_we), .wr_data(evt_wdata), .sts(evt_sts)
  );

  brg_irq_comb #(.EVT_W(EVT_W)) u_comb (
    .clk(clk), .rst_n(rst_n_s), .sts(evt_sts), .msk(msk),
    .glb_en(glb_en), .irq(irq_out)
  );

  // R12: error flags with no event pending cannot raise the line
  p_err_only_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt_sts == '0) |=> !irq_out);

  // R1: line is low in the first cycle out of reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n_s |=> !irq_out);
endmodule

// File: tb/brg_irq_ctrl_tb.sv
`timescale 1ns/1ps
module brg_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_hidx;
  logic        reg_wr;
  logic [1:0]  reg_be;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [3:0]  bus_err_pulse;
  logic [7:0]  lb_evt_pulse;
  logic        irq_out;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  logic        done   = 1'b0;

  always #2.5 clk = ~clk;

  brg_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_hidx(reg_hidx), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_err_pulse(bus_err_pulse), .lb_evt_pulse(lb_evt_pulse),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [1:0] b,
                     input logic [15:0] d, input logic [3:0] ep, input logic [7:0] vp);
    @(negedge clk);
    reg_wr = w; reg_hidx = a; reg_be = b; reg_wdata = d;
    bus_err_pulse = ep; lb_evt_pulse = vp;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00; bus_err_pulse = '0; lb_evt_pulse = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    reg_hidx = a;
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; reg_hidx = '0; reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
    bus_err_pulse = '0; lb_evt_pulse = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, 16'h0000, "R1 err");
    rd(2'd1, 16'h0000, "R1 evt/msk");
    rd(2'd2, 16'h0000, "R1 ctl");
    chk("R1 irq", {15'b0, irq_out}, 16'h0000);

    // R2 flag positions, accumulating
    v = 16'h0000;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 2'd0, 2'b00, 16'h0, 4'(1 << i), 8'h00);
      v = v | 16'(1 << (12 + i));
      rd(2'd0, v, "R2 flag set");
    end
    // R10 lane 0 does not reach the flags
    cyc(1'b1, 2'd0, 2'b01, 16'hF000, 4'h0, 8'h00);
    rd(2'd0, 16'hF000, "R10 err lane0");
    // R3 ones clear, zeros keep
    cyc(1'b1, 2'd0, 2'b11, 16'h5000, 4'h0, 8'h00);
    rd(2'd0, 16'hA000, "R3 w1c partial");
    // R3 write back what was read
    reg_hidx = 2'd0; #0.5; v = reg_rdata;
    cyc(1'b1, 2'd0, 2'b10, v, 4'h0, 8'h00);
    rd(2'd0, 16'h0000, "R3 write-back");
    // R9 set beats clear on flags
    cyc(1'b0, 2'd0, 2'b00, 16'h0, 4'h8, 8'h00);
    cyc(1'b1, 2'd0, 2'b10, 16'hF000, 4'h8, 8'h00);
    rd(2'd0, 16'h8000, "R9 err set wins");
    cyc(1'b1, 2'd0, 2'b10, 16'hF000, 4'h0, 8'h00);

    // R4 events
    cyc(1'b0, 2'd0, 2'b00, 16'h0, 4'h0, 8'hA5);
    rd(2'd1, 16'h00A5, "R4 evt set");
    cyc(1'b0, 2'd0, 2'b00, 16'h0, 4'h0, 8'h00);
    rd(2'd1, 16'h00A5, "R4 evt hold");
    // R5 zeros clear
    cyc(1'b1, 2'd1, 2'b01, 16'h0021, 4'h0, 8'h00);
    rd(2'd1, 16'h0021, "R5 partial clear");
    cyc(1'b1, 2'd1, 2'b01, 16'h0000, 4'h0, 8'h00);
    rd(2'd1, 16'h0000, "R5 clear all");
    // R9 set beats clear on events
    cyc(1'b1, 2'd1, 2'b01, 16'h0000, 4'h0, 8'h04);
    rd(2'd1, 16'h0004, "R9 evt set wins");

    // R6 mask
    cyc(1'b1, 2'd1, 2'b10, 16'h3C00, 4'h0, 8'h00);
    rd(2'd1, 16'h3C04, "R6 mask write");
    // R10 mask lane off
    cyc(1'b1, 2'd1, 2'b01, 16'hFF04, 4'h0, 8'h00);
    rd(2'd1, 16'h3C04, "R10 mask lane1 off");

    // R7 control
    cyc(1'b1, 2'd2, 2'b11, 16'hFFFF, 4'h0, 8'h00);
    rd(2'd2, 16'h0400, "R7 enable only");
    cyc(1'b1, 2'd2, 2'b01, 16'h0000, 4'h0, 8'h00);
    rd(2'd2, 16'h0400, "R10 ctl lane0");
    cyc(1'b1, 2'd2, 2'b10, 16'h0000, 4'h0, 8'h00);
    rd(2'd2, 16'h0000, "R7 disable");

    // R11 unmapped
    cyc(1'b1, 2'd3, 2'b11, 16'hFFFF, 4'h0, 8'h00);
    rd(2'd3, 16'h0000, "R11 read zero");
    rd(2'd1, 16'h3C04, "R11 evt/msk kept");
    rd(2'd2, 16'h0000, "R11 ctl kept");

    // R12 errors alone, everything open
    cyc(1'b1, 2'd1, 2'b11, 16'hFF00, 4'h0, 8'h00);
    cyc(1'b1, 2'd2, 2'b10, 16'h0400, 4'hF, 8'h00);
    @(negedge clk);
    chk("R12 errors only", {15'b0, irq_out}, 16'h0000);
    cyc(1'b1, 2'd0, 2'b10, 16'hF000, 4'h0, 8'h00);

    // R8 latency on rise and fall
    cyc(1'b0, 2'd0, 2'b00, 16'h0, 4'h0, 8'h01);
    chk("R8 not yet high", {15'b0, irq_out}, 16'h0000);
    @(negedge clk);
    chk("R8 high", {15'b0, irq_out}, 16'h0001);
    cyc(1'b1, 2'd1, 2'b01, 16'h0000, 4'h0, 8'h00);
    chk("R8 still high", {15'b0, irq_out}, 16'h0001);
    @(negedge clk);
    chk("R8 low after clear", {15'b0, irq_out}, 16'h0000);

    // R8 sweep: every mask against every single source
    for (int m = 0; m < 256; m++) begin
      cyc(1'b1, 2'd1, 2'b10, {8'(m), 8'h00}, 4'h0, 8'h00);
      for (int k = 0; k < 8; k++) begin
        cyc(1'b1, 2'd1, 2'b01, 16'h0000, 4'h0, 8'h00);
        cyc(1'b0, 2'd0, 2'b00, 16'h0, 4'h0, 8'(1 << k));
        @(negedge clk);
        chk($sformatf("R8 m=%0h k=%0d", m, k), {15'b0, irq_out},
            {15'b0, 1'((m >> k) & 1)});
      end
    end

    // R8 enable off: nothing gets out for any mask
    cyc(1'b1, 2'd2, 2'b10, 16'h0000, 4'h0, 8'h00);
    for (int m = 0; m < 256; m++) begin
      cyc(1'b1, 2'd1, 2'b11, {8'(m), 8'h00}, 4'h0, 8'h00);
      cyc(1'b0, 2'd0, 2'b00, 16'h0, 4'h0, 8'hFF);
      @(negedge clk);
      chk($sformatf("R8 gated m=%0h", m), {15'b0, irq_out}, 16'h0000);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule